// File: doc/BRIEF.md
# Segmented Physical Address Generator

This block keeps four 16-bit segment base registers (extra, code, stack and data) and turns a segment choice and a 16-bit offset into a 20-bit physical address. The selected segment value is moved up four bit positions, which makes it a base on a 16-byte boundary, and the offset is added to it. The adder drops the carry out of the top bit, so any address past the 1 MB limit wraps to the bottom of the space. Each segment covers 64 KB above its base, and segments may overlap.

A write port loads any one segment register. A request port takes a segment select and an offset. One clock later the block presents the registered address together with a valid flag. For instruction fetch, the caller selects the code segment and supplies the instruction pointer as the offset. The caller decides which offset source to use. No access checking is done.

Top module: `seg_addr_gen`

## Requirements
- R1: While `rst` is high at a clock edge, all four segment registers clear to 0, `out_valid` clears to 0 and `out_addr` clears to 0.
- R2: A request accepted at a clock edge (`req_valid` high) gives `out_addr = ((seg << 4) + req_off) mod 2^20`, visible after that same edge, where `seg` is the selected register's value before that edge.
- R3: `out_valid` equals the `req_valid` value sampled at the previous edge. When no request is accepted, `out_addr` keeps its previous value.
- R4: The segment select encoding, for both `req_sel` and `wr_sel`, is 2'b00 extra, 2'b01 code, 2'b10 stack and 2'b11 data.
- R5: A segment write takes effect on the address computed in the next cycle. A request in the same cycle as a write to the same segment uses the old value.
- R6: A carry out of bit 19 is discarded. For example, segment 0xFFFF with offset 0x0010 gives 0x00000, and segment 0xFFFF with offset 0xFFFF gives 0x0FFEF.
- R7: A write changes only the register named by `wr_sel`. The other three keep their values, even when two segments hold the same or overlapping bases.
- R8: Segment 0x1005 with offset 0x5555 gives physical address 0x155A5.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| wr_en | input | 1 | Segment register write enable |
| wr_sel | input | 2 | Segment register to write (R4 encoding) |
| wr_data | input | 16 | New segment value |
| req_valid | input | 1 | Address request strobe |
| req_sel | input | 2 | Segment used for the request (R4 encoding) |
| req_off | input | 16 | Offset added to the segment base |
| out_valid | output | 1 | Registered address is new this cycle |
| out_addr | output | 20 | Registered 20-bit physical address |

## Verification
The bound checker mirrors the four segment registers from the write port. On every cycle it checks four things:
- the registered address against the shift-and-add of the selected mirror value, including the wrap;
- the one-cycle relation between `req_valid` and `out_valid`;
- address hold while idle;
- the reset values.

Some behaviour shows only in the bench's directed scenarios:
- the exact select encoding;
- old-value use when a write and a request to the same segment share a cycle;
- independence of overlapping segments;
- the specific wrap and example values.

// File: rtl/seg_addr_pkg.sv
package seg_addr_pkg;
  localparam int SEG_W  = 16;
  localparam int OFF_W  = 16;
  localparam int SHIFT  = 4;
  localparam int ADDR_W = 20;
  localparam int NSEG   = 4;
  localparam int SEL_W  = $clog2(NSEG);

  typedef enum logic [1:0] {
    SEG_EXTRA = 2'b00,
    SEG_CODE  = 2'b01,
    SEG_STACK = 2'b10,
    SEG_DATA  = 2'b11
  } seg_sel_e;
endpackage

// File: rtl/seg_regfile.sv
module seg_regfile #(
  parameter int NUM   = 4,
  parameter int SEG_W = 16,
  localparam int SEL_W = $clog2(NUM)
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             wr_en,
  input  logic [SEL_W-1:0] wr_idx,
  input  logic [SEG_W-1:0] wr_data,
  input  logic [SEL_W-1:0] rd_idx,
  output logic [SEG_W-1:0] rd_data
);
  logic [SEG_W-1:0] seg_q [NUM];

  for (genvar g = 0; g < NUM; g++) begin : g_seg
    always_ff @(posedge clk) begin
      if (rst)
        seg_q[g] <= '0;
      else if (wr_en && (wr_idx == SEL_W'(g)))
        seg_q[g] <= wr_data;
    end
  end

  assign rd_data = seg_q[rd_idx];
endmodule

// File: rtl/seg_offset_add.sv
module seg_offset_add #(
  parameter int SEG_W  = 16,
  parameter int OFF_W  = 16,
  parameter int SHIFT  = 4,
  parameter int ADDR_W = 20,
  localparam int BASE_W = SEG_W + SHIFT,
  localparam int SUM_W  = ((BASE_W > OFF_W) ? BASE_W : OFF_W) + 1
) (
  input  logic [SEG_W-1:0]  seg,
  input  logic [OFF_W-1:0]  off,
  output logic [ADDR_W-1:0] addr
);
  logic [BASE_W-1:0] base;
  logic [SUM_W-1:0]  sum;

  assign base = {seg, {SHIFT{1'b0}}};
  assign sum  = SUM_W'(base) + SUM_W'(off);
  assign addr = sum[ADDR_W-1:0];
endmodule

// File: rtl/seg_addr_gen.sv
module seg_addr_gen #(
  parameter int SEG_W  = seg_addr_pkg::SEG_W,
  parameter int OFF_W  = seg_addr_pkg::OFF_W,
  parameter int SHIFT  = seg_addr_pkg::SHIFT,
  parameter int ADDR_W = seg_addr_pkg::ADDR_W,
  parameter int NSEG   = seg_addr_pkg::NSEG,
  localparam int SEL_W = $clog2(NSEG)
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              wr_en,
  input  logic [SEL_W-1:0]  wr_sel,
  input  logic [SEG_W-1:0]  wr_data,
  input  logic              req_valid,
  input  logic [SEL_W-1:0]  req_sel,
  input  logic [OFF_W-1:0]  req_off,
  output logic              out_valid,
  output logic [ADDR_W-1:0] out_addr
);
  logic [SEG_W-1:0]  seg_val;
  logic [ADDR_W-1:0] addr_d;

  seg_regfile #(.NUM(NSEG), .SEG_W(SEG_W)) u_regs (
    .clk     (clk),
    .rst     (rst),
    .wr_en   (wr_en),
    .wr_idx  (wr_sel),
    .wr_data (wr_data),
    .rd_idx  (req_sel),
    .rd_data (seg_val)
  );

  seg_offset_add #(.SEG_W(SEG_W), .OFF_W(OFF_W), .SHIFT(SHIFT), .ADDR_W(ADDR_W)) u_add (
    .seg  (seg_val),
    .off  (req_off),
    .addr (addr_d)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      out_valid <= 1'b0;
      out_addr  <= '0;
    end else begin
      out_valid <= req_valid;
      if (req_valid) out_addr <= addr_d;
    end
  end
endmodule

// File: rtl/seg_addr_gen_chk.sv
module seg_addr_gen_chk #(
  parameter int SEG_W  = 16,
  parameter int OFF_W  = 16,
  parameter int SHIFT  = 4,
  parameter int ADDR_W = 20,
  parameter int NSEG   = 4,
  localparam int SEL_W = $clog2(NSEG)
) (
  input logic              clk,
  input logic              rst,
  input logic              wr_en,
  input logic [SEL_W-1:0]  wr_sel,
  input logic [SEG_W-1:0]  wr_data,
  input logic              req_valid,
  input logic [SEL_W-1:0]  req_sel,
  input logic [OFF_W-1:0]  req_off,
  input logic              out_valid,
  input logic [ADDR_W-1:0] out_addr
);
  logic [SEG_W-1:0]  mirror [NSEG];
  logic [ADDR_W-1:0] exp_q;
  logic [ADDR_W+SHIFT:0] wide;

  assign wide = (ADDR_W+SHIFT+1)'({mirror[req_sel], {SHIFT{1'b0}}}) + (ADDR_W+SHIFT+1)'(req_off);

  always_ff @(posedge clk) begin
    if (rst) begin
      for (int i = 0; i < NSEG; i++) mirror[i] <= '0;
      exp_q <= '0;
    end else begin
      if (wr_en) mirror[wr_sel] <= wr_data;
      if (req_valid) exp_q <= wide[ADDR_W-1:0];
    end
  end

  // R1
  reset_clear_chk: assert property (@(posedge clk) disable iff (rst)
    $past(rst) |-> (!out_valid && out_addr == '0));
  // R2
  addr_match_chk: assert property (@(posedge clk) disable iff (rst)
    out_valid |-> out_addr == exp_q);
  // R3
  valid_follow_chk: assert property (@(posedge clk) disable iff (rst)
    req_valid |=> out_valid);
  // R3
  idle_low_chk: assert property (@(posedge clk) disable iff (rst)
    !req_valid |=> !out_valid);
  // R3
  idle_hold_chk: assert property (@(posedge clk) disable iff (rst)
    !req_valid |=> $stable(out_addr));
endmodule

bind seg_addr_gen seg_addr_gen_chk #(
  .SEG_W(SEG_W), .OFF_W(OFF_W), .SHIFT(SHIFT), .ADDR_W(ADDR_W), .NSEG(NSEG)
) u_chk (
  .clk(clk), .rst(rst), .wr_en(wr_en), .wr_sel(wr_sel), .wr_data(wr_data),
  .req_valid(req_valid), .req_sel(req_sel), .req_off(req_off),
  .out_valid(out_valid), .out_addr(out_addr)
);

// File: tb/test_seg_addr_gen.sv
`timescale 1ns/1ps
module test_seg_addr_gen;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        wr_en = 1'b0;
  logic [1:0]  wr_sel = '0;
  logic [15:0] wr_data = '0;
  logic        req_valid = 1'b0;
  logic [1:0]  req_sel = '0;
  logic [15:0] req_off = '0;
  logic        out_valid;
  logic [19:0] out_addr;

  int checks = 0;
  int errors = 0;
  bit done = 0;

  int m_seg [4];
  int m_addr;
  bit m_valid;

  always #2.5 clk = ~clk;

  seg_addr_gen i_seg_addr_gen (
    .clk(clk), .rst(rst), .wr_en(wr_en), .wr_sel(wr_sel), .wr_data(wr_data),
    .req_valid(req_valid), .req_sel(req_sel), .req_off(req_off),
    .out_valid(out_valid), .out_addr(out_addr)
  );

  task automatic check(string req, int act, int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s: actual 0x%05h expected 0x%05h", req, act, exp);
    end
  endtask

  task automatic step(input bit we, input int ws, input int wd,
                      input bit rv, input int rs, input int off, input string req);
    @(negedge clk);
    wr_en = we; wr_sel = 2'(ws); wr_data = 16'(wd);
    req_valid = rv; req_sel = 2'(rs); req_off = 16'(off);
    @(posedge clk);
    if (rst) begin
      for (int i = 0; i < 4; i++) m_seg[i] = 0;
      m_valid = 0; m_addr = 0;
    end else begin
      m_valid = rv;
      if (rv) m_addr = ((m_seg[rs] << 4) + off) & 32'hFFFFF;
      if (we) m_seg[ws] = wd;
    end
    #1;
    check({req, " valid"}, int'(out_valid), int'(m_valid));
    check({req, " addr"}, int'(out_addr), m_addr);
  endtask

  initial begin
    #(5.0 * 5000);
    if (!done) begin
      errors++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    // R1 reset state
    step(0, 0, 0, 1, 1, 16'h1234, "R1");
    step(0, 0, 0, 0, 0, 0, "R1");
    rst = 1'b0;
    step(0, 0, 0, 1, 3, 16'h0040, "R1 segs zero");
    // R4 R2: load each segment via its code
    step(1, 0, 16'h7000, 0, 0, 0, "R4 load extra");
    step(1, 1, 16'h348A, 0, 0, 0, "R4 load code");
    step(1, 2, 16'h5000, 0, 0, 0, "R4 load stack");
    step(1, 3, 16'h2000, 0, 0, 0, "R4 load data");
    step(0, 0, 0, 1, 0, 16'hFFFF, "R4 extra top");
    step(0, 0, 0, 1, 1, 16'hFFFF, "R4 code top");
    step(0, 0, 0, 1, 2, 16'hFFFF, "R4 stack top");
    step(0, 0, 0, 1, 3, 16'hFFFF, "R4 data top");
    step(0, 0, 0, 1, 1, 16'h0000, "R2 code base");
    // R3 idle hold
    step(0, 0, 0, 0, 2, 16'h1111, "R3 idle");
    step(0, 0, 0, 0, 0, 16'h2222, "R3 idle");
    // R8 example
    step(1, 3, 16'h1005, 0, 0, 0, "R8 load");
    step(0, 0, 0, 1, 3, 16'h5555, "R8");
    // R5 same-cycle write and read uses old value, next uses new
    step(1, 2, 16'h0100, 1, 2, 16'h0004, "R5 old");
    step(0, 0, 0, 1, 2, 16'h0004, "R5 new");
    // R6 wrap
    step(1, 0, 16'hFFFF, 0, 0, 0, "R6 load");
    step(0, 0, 0, 1, 0, 16'h0010, "R6 wrap zero");
    step(0, 0, 0, 1, 0, 16'hFFFF, "R6 wrap max");
    step(0, 0, 0, 1, 0, 16'h000F, "R6 no wrap");
    // R7 overlapping segments stay independent
    step(1, 1, 16'h1005, 0, 0, 0, "R7 load");
    step(0, 0, 0, 1, 3, 16'h0001, "R7 data kept");
    step(0, 0, 0, 1, 1, 16'h0001, "R7 code");
    step(0, 0, 0, 1, 2, 16'h0000, "R7 stack kept");
    step(0, 0, 0, 1, 0, 16'h0000, "R7 extra kept");
    // R2 mixed traffic
    for (int k = 0; k < 300; k++)
      step(1'($urandom), int'($urandom % 4), int'($urandom & 16'hFFFF),
           1'($urandom), int'($urandom % 4), int'($urandom & 16'hFFFF), "R2 mixed");
    // R1 reset again clears segments
    rst = 1'b1;
    step(0, 0, 0, 0, 0, 0, "R1 re-reset");
    rst = 1'b0;
    step(0, 0, 0, 1, 2, 16'h0ABC, "R1 segs cleared");
    done = 1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule